// File: doc/BRIEF.md
# Programmable Multi-Mode Interrupt Controller

This block collects up to 32 interrupt sources and turns them into two request lines and one wake line for a processor. Each source has a 3-bit trigger code that selects rising edge, falling edge, either edge, active-high level, active-low level, or off. It also has a mask enable, a wake enable, a route bit that picks one of the two request lines, and a source-select bit. The source-select bit chooses between the external pin and a bit of a software-writable test register.

Software reaches the block through a simple word-addressed write port with a combinational read path. Each per-source setting has three addresses: a set address, a clear address and a readback address. Because of this, bits can change without a read-modify-write. Edge events are latched until software clears them. Two read-only status words show, for each request line, which sources are pending, unmasked and routed to that line.

Top module: `irq_hub`

## Requirements
- R1: After reset the trigger-code, mask, wake, rise-latch, fall-latch and test registers read 0. The route and source-select registers read all ones. `irq0_o`, `irq1_o` and `wake_o` are low.
- R2: The trigger code of a source is {c2,c1,c0}, taken from bit n of the c2, c1 and c0 registers: 001 rising edge, 010 falling edge, 011 either edge, 101 active-high level, 110 active-low level. Code 000 and the unlisted codes 100 and 111 never make the source pending.
- R3: Every setting group g has word addresses 4g (read), 4g+1 (write ones to set) and 4g+2 (write ones to clear). The groups are: 0 c0, 1 c1, 2 c2, 3 mask, 4 wake, 5 route, 6 source-select. Zero bits of a write leave the register unchanged, and the read address returns the current value.
- R4: A source with route bit 1 is reported on request line 0. A source with route bit 0 is reported on request line 1. No source appears on both.
- R5: In an edge mode, a qualifying edge of the selected source sets its rise latch (address 28) or fall latch (address 30). The bit stays set until a one is written to the same bit of address 29 (rise clear) or address 31 (fall clear). Clearing one bit leaves all other bits unchanged.
- R6: A source drives a request line only while its mask bit is 1. Clearing the mask stops the request but leaves the latched edge, so setting the mask again brings the request back.
- R7: Address 32 returns pending & mask & route, and address 33 returns pending & mask & ~route. `irq0_o` is the OR of address 32 and `irq1_o` is the OR of address 33.
- R8: `wake_o` is high exactly when some pending source has its wake bit set, whatever its mask.
- R9: A source with source-select 1 samples its input pin. A source with source-select 0 samples bit n of the test register (address 34, plain write and read).
- R10: Level modes are not latched. A level source's pending bit follows its sampled input (inverted for active-low), two clocks after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt source pins |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq0_o | output | 1 | Request line 0 |
| irq1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
On every cycle, the assertions check four things: set and clear writes take effect, latched edges drop only under a clear write, the two status words never overlap or include a masked source, and wake never rises without a pending wake-enabled source. The bench's scenarios are needed to show the behaviour that depends on history. This covers which trigger codes latch which edge, level tracking and its polarity, the source-select path through the test register, and a latch that outlives a mask toggle. Random mixes of pin changes and register writes are compared against a bench model after each operation.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int ADDR_W     = 6;
    localparam int NGRP       = 7;
    localparam int GRP_C0     = 0;
    localparam int GRP_C1     = 1;
    localparam int GRP_C2     = 2;
    localparam int GRP_MASK   = 3;
    localparam int GRP_WAKE   = 4;
    localparam int GRP_ROUTE  = 5;
    localparam int GRP_SRCSEL = 6;

    localparam int OFS_RD  = 0;
    localparam int OFS_SET = 1;
    localparam int OFS_CLR = 2;

    localparam logic [ADDR_W-1:0] A_RISE_RD  = 6'd28;
    localparam logic [ADDR_W-1:0] A_RISE_CLR = 6'd29;
    localparam logic [ADDR_W-1:0] A_FALL_RD  = 6'd30;
    localparam logic [ADDR_W-1:0] A_FALL_CLR = 6'd31;
    localparam logic [ADDR_W-1:0] A_STAT0    = 6'd32;
    localparam logic [ADDR_W-1:0] A_STAT1    = 6'd33;
    localparam logic [ADDR_W-1:0] A_TEST     = 6'd34;

    function automatic logic [ADDR_W-1:0] grp_addr(int g, int ofs);
        return ADDR_W'(g * 4 + ofs);
    endfunction
endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
    import irq_hub_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NSRC-1:0]            wdata,
    output logic [NGRP-1:0][NSRC-1:0]  grp_q,
    output logic [NSRC-1:0]            test_q
);
    typedef struct packed {
        logic [NGRP-1:0][NSRC-1:0] grp;
        logic [NSRC-1:0]           test;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NGRP; g++) begin
            if (wr_en && addr == grp_addr(g, OFS_SET))
                st_d.grp[g] = st_q.grp[g] | wdata;
            if (wr_en && addr == grp_addr(g, OFS_CLR))
                st_d.grp[g] = st_q.grp[g] & ~wdata;
        end
        if (wr_en && addr == A_TEST)
            st_d.test = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.grp[GRP_ROUTE]  <= '1;
            st_q.grp[GRP_SRCSEL] <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_q  = st_q.grp;
    assign test_q = st_q.test;

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == grp_addr(g, OFS_SET)) |=> ((grp_q[g] & $past(wdata)) == $past(wdata)));
        a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == grp_addr(g, OFS_CLR)) |=> ((grp_q[g] & $past(wdata)) == '0));
    end
endmodule

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw_i,
    output logic [NSRC-1:0] smp_o,
    output logic [NSRC-1:0] prv_o
);
    typedef struct packed {
        logic [NSRC-1:0] meta;
        logic [NSRC-1:0] smp;
        logic [NSRC-1:0] prv;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = raw_i;
        st_d.smp  = st_q.meta;
        st_d.prv  = st_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o = st_q.smp;
    assign prv_o = st_q.prv;
endmodule

// File: rtl/irq_hub_detect.sv
module irq_hub_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] smp_i,
    input  logic [NSRC-1:0] prv_i,
    input  logic [NSRC-1:0] c0_i,
    input  logic [NSRC-1:0] c1_i,
    input  logic [NSRC-1:0] c2_i,
    input  logic [NSRC-1:0] rise_clr_i,
    input  logic [NSRC-1:0] fall_clr_i,
    output logic [NSRC-1:0] rise_q_o,
    output logic [NSRC-1:0] fall_q_o,
    output logic [NSRC-1:0] pend_o
);
    typedef struct packed {
        logic [NSRC-1:0] rise;
        logic [NSRC-1:0] fall;
    } det_st_t;

    det_st_t st_d, st_q;
    logic [NSRC-1:0] rise_evt, fall_evt;

    always_comb begin
        rise_evt = smp_i & ~prv_i & ~c2_i & c0_i;
        fall_evt = ~smp_i & prv_i & ~c2_i & c1_i;
        st_d.rise = (st_q.rise & ~rise_clr_i) | rise_evt;
        st_d.fall = (st_q.fall & ~fall_clr_i) | fall_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_pend
        always_comb begin
            case ({c2_i[n], c1_i[n], c0_i[n]})
                3'b001:  pend_o[n] = st_q.rise[n];
                3'b010:  pend_o[n] = st_q.fall[n];
                3'b011:  pend_o[n] = st_q.rise[n] | st_q.fall[n];
                3'b101:  pend_o[n] = smp_i[n];
                3'b110:  pend_o[n] = ~smp_i[n];
                default: pend_o[n] = 1'b0;
            endcase
        end
    end

    assign rise_q_o = st_q.rise;
    assign fall_q_o = st_q.fall;

    a_r5_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(rise_q_o) & ~rise_q_o) & ~$past(rise_clr_i)) == '0));
    a_r5_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(fall_q_o) & ~fall_q_o) & ~$past(fall_clr_i)) == '0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq0_o,
    output logic              irq1_o,
    output logic              wake_o
);
    logic [NGRP-1:0][NSRC-1:0] grp_q;
    logic [NSRC-1:0] test_q, raw_sel, smp, prv;
    logic [NSRC-1:0] rise_q, fall_q, pend;
    logic [NSRC-1:0] rise_clr, fall_clr, stat0, stat1;

    irq_hub_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .grp_q(grp_q), .test_q(test_q)
    );

    assign raw_sel = (src_i & grp_q[GRP_SRCSEL]) | (test_q & ~grp_q[GRP_SRCSEL]);

    irq_hub_sync #(.NSRC(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_sel), .smp_o(smp), .prv_o(prv)
    );

    assign rise_clr = (bus_wr && bus_addr == A_RISE_CLR) ? bus_wdata : '0;
    assign fall_clr = (bus_wr && bus_addr == A_FALL_CLR) ? bus_wdata : '0;

    irq_hub_detect #(.NSRC(NSRC)) u_det (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .prv_i(prv),
        .c0_i(grp_q[GRP_C0]), .c1_i(grp_q[GRP_C1]), .c2_i(grp_q[GRP_C2]),
        .rise_clr_i(rise_clr), .fall_clr_i(fall_clr),
        .rise_q_o(rise_q), .fall_q_o(fall_q), .pend_o(pend)
    );

    assign stat0  = pend & grp_q[GRP_MASK] & grp_q[GRP_ROUTE];
    assign stat1  = pend & grp_q[GRP_MASK] & ~grp_q[GRP_ROUTE];
    assign irq0_o = |stat0;
    assign irq1_o = |stat1;
    assign wake_o = |(pend & grp_q[GRP_WAKE]);

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NGRP; g++)
            if (bus_addr == grp_addr(g, OFS_RD)) bus_rdata = grp_q[g];
        case (bus_addr)
            A_RISE_RD: bus_rdata = rise_q;
            A_FALL_RD: bus_rdata = fall_q;
            A_STAT0:   bus_rdata = stat0;
            A_STAT1:   bus_rdata = stat1;
            A_TEST:    bus_rdata = test_q;
            default:   ;
        endcase
    end

    a_r4_lines_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 & stat1) == '0);
    a_r6_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 | stat1) & ~grp_q[GRP_MASK]) == '0);
    a_r8_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ((pend & grp_q[GRP_WAKE]) != '0));
    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0_o || irq1_o) |-> ((pend & grp_q[GRP_MASK]) != '0));
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          wr = 1'b0;
    logic [5:0]    addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq0, irq1, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [N-1:0] m_grp [7];
    logic [N-1:0] m_test, m_rise, m_fall, m_prev;

    always #10 clk = ~clk;

    irq_hub u_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq0_o(irq0), .irq1_o(irq1), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] eff_src();
        return (src & m_grp[6]) | (m_test & ~m_grp[6]);
    endfunction

    function automatic logic [N-1:0] exp_pend();
        logic [N-1:0] p;
        logic [N-1:0] s;
        s = eff_src();
        for (int n = 0; n < N; n++) begin
            case ({m_grp[2][n], m_grp[1][n], m_grp[0][n]})
                3'b001:  p[n] = m_rise[n];
                3'b010:  p[n] = m_fall[n];
                3'b011:  p[n] = m_rise[n] | m_fall[n];
                3'b101:  p[n] = s[n];
                3'b110:  p[n] = ~s[n];
                default: p[n] = 1'b0;
            endcase
        end
        return p;
    endfunction

    task automatic rd(input logic [5:0] a, output logic [N-1:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wr_word(input logic [5:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    // settle, advance the model's edge latches, compare everything
    task automatic settle_and_check(input int grp_peek);
        logic [N-1:0] s, p, v;
        repeat (4) @(negedge clk);
        s = eff_src();
        m_rise |= s & ~m_prev & ~m_grp[2] & m_grp[0];
        m_fall |= ~s & m_prev & ~m_grp[2] & m_grp[1];
        m_prev = s;
        p = exp_pend();
        rd(6'd32, v); chk("R7 stat0", v, p & m_grp[3] & m_grp[5]);
        rd(6'd33, v); chk("R4 stat1", v, p & m_grp[3] & ~m_grp[5]);
        chk("R7 irq0", N'(irq0), N'(|(p & m_grp[3] & m_grp[5])));
        chk("R7 irq1", N'(irq1), N'(|(p & m_grp[3] & ~m_grp[5])));
        chk("R8 wake", N'(wake), N'(|(p & m_grp[4])));
        rd(6'd28, v); chk("R5 rise latch", v, m_rise);
        rd(6'd30, v); chk("R5 fall latch", v, m_fall);
        rd(6'(grp_peek * 4), v); chk("R3 readback", v, m_grp[grp_peek]);
    endtask

    task automatic op_set(input int g, input logic [N-1:0] d);
        wr_word(6'(g * 4 + 1), d); m_grp[g] |= d; settle_and_check(g);
    endtask
    task automatic op_clr(input int g, input logic [N-1:0] d);
        wr_word(6'(g * 4 + 2), d); m_grp[g] &= ~d; settle_and_check(g);
    endtask
    task automatic op_src(input logic [N-1:0] d);
        @(negedge clk); src = d; settle_and_check(3);
    endtask
    task automatic op_test(input logic [N-1:0] d);
        logic [N-1:0] v;
        wr_word(6'd34, d); m_test = d;
        rd(6'd34, v); chk("R9 test readback", v, d);
        settle_and_check(6);
    endtask
    task automatic op_rclr(input logic [N-1:0] d);
        wr_word(6'd29, d); m_rise &= ~d; settle_and_check(0);
    endtask
    task automatic op_fclr(input logic [N-1:0] d);
        wr_word(6'd31, d); m_fall &= ~d; settle_and_check(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [N-1:0] v;
        void'($urandom(32'd4242));
        for (int g = 0; g < 7; g++) m_grp[g] = (g >= 5) ? '1 : '0;
        m_test = '0; m_rise = '0; m_fall = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int g = 0; g < 7; g++) begin
            rd(6'(g * 4), v); chk("R1 reset group", v, (g >= 5) ? '1 : '0);
        end
        rd(6'd28, v); chk("R1 reset rise", v, '0);
        rd(6'd30, v); chk("R1 reset fall", v, '0);
        rd(6'd34, v); chk("R1 reset test", v, '0);
        chk("R1 reset outputs", N'({irq0, irq1, wake}), '0);

        // R2/R5/R6: source 3 rising edge, masked in, routed to line 0
        op_set(3, 32'h0000_0008);
        op_set(0, 32'h0000_0008);
        op_src(32'h0000_0008);
        op_clr(3, 32'h0000_0008);       // R6 mask off, latch kept
        op_set(3, 32'h0000_0008);       // R6 request returns
        op_rclr(32'h0000_0008);         // R5 clear
        // R2 falling edge on source 5, routed to line 1 (R4), wake on (R8)
        op_set(1, 32'h0000_0020); op_set(3, 32'h0000_0020);
        op_clr(5, 32'h0000_0020); op_set(4, 32'h0000_0020);
        op_src(32'h0000_0028);
        op_src(32'h0000_0008);
        op_fclr(32'h0000_0020);
        // R10 active-low level on source 9, active-high on 10
        op_set(2, 32'h0000_0600); op_set(1, 32'h0000_0200); op_set(0, 32'h0000_0400);
        op_set(3, 32'h0000_0600);
        op_src(32'h0000_0408);
        op_src(32'h0000_0208);
        // R9 test register path on source 10
        op_clr(6, 32'h0000_0400);
        op_test(32'h0000_0400);
        op_test(32'h0000_0000);
        op_set(6, 32'h0000_0400);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            int g;
            k = int'($urandom_range(0, 7));
            g = int'($urandom_range(0, 6));
            case (k)
                0, 1:    op_src(src ^ ($urandom() & $urandom()));
                2:       op_set(g, $urandom() & $urandom());
                3:       op_clr(g, $urandom() & $urandom());
                4:       op_set(3, $urandom());
                5:       op_rclr($urandom());
                6:       op_fclr($urandom());
                default: op_test($urandom());
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule